// File: doc/BRIEF.md
# Multi-Function Integer ALU

A purely combinational arithmetic-logic unit for integer datapaths. It takes two WIDTH-bit operands and a 3-bit operation code. From these it produces a result word, a zero flag, a carry-out and a signed overflow flag. No register sits anywhere in the block, so every output follows its inputs within the same cycle.

One ripple adder serves addition, subtraction and the signed less-than compare. For subtraction the second operand is inverted and the carry-in is forced to one. The less-than decision takes the sign of the difference and corrects it by the overflow bit, so it stays right when the difference overflows. The zero flag lets a datapath test equal and not-equal by subtracting and looking at the flag. Two spare codes add exclusive-or and not-or when the option parameter enables them.

Top module: `intalu_core`

## Requirements
- R1: Code 000 gives the bitwise AND of the two operands.
- R2: Code 001 gives the bitwise OR of the two operands.
- R3: Code 010 gives the sum modulo 2^WIDTH. The carry-out is the carry out of the top bit of that sum.
- R4: Code 110 gives A minus B modulo 2^WIDTH. It is computed as A plus inverted B plus one, and the carry-out is the top carry of that sum. The carry-out is therefore 1 when A >= B unsigned.
- R5: Code 111 gives 1 in bit 0 when A < B as signed two's-complement numbers, and 0 otherwise. All higher bits are 0. The answer is correct even when A minus B overflows. For this code, carry-out and overflow are 0.
- R6: The zero flag is 1 exactly when every bit of the result is 0, for every code.
- R7: For codes 010 and 110 the overflow flag is 1 exactly when the adder's two inputs (B already inverted for 110) have the same sign and the sum's sign differs from it.
- R8: For codes 000, 001, 011 and 100, both carry-out and overflow are 0.
- R9: With the extension enabled, code 011 gives the bitwise XOR of the operands.
- R10: With the extension enabled, code 100 gives the bitwise NOR of the operands.
- R11: Code 101 gives a result of 0 with the zero flag at 1 and carry-out and overflow at 0. Codes 011 and 100 behave the same way when the extension is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First operand |
| opd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code |
| res_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is all zeros |
| cout_o | output | 1 | Adder carry-out for add and subtract |
| ovf_o | output | 1 | Signed overflow for add and subtract |

## Verification
The hardest cases to reach are the compares and subtractions whose difference overflows. Examples are the most negative value against any positive value, and the most positive value against any negative value. In these cases the raw sign of the difference gives the wrong less-than answer. A directed corner set pairs the extreme values 0, 1, all-ones, the most positive and the most negative value with one another under every code. A pseudo-random stream then sweeps all eight codes, so ordinary carries and overflows show up in large numbers.

// File: rtl/intalu_pkg.sv
package intalu_pkg;
   typedef enum logic [2:0] {
      ALU_AND  = 3'b000,
      ALU_OR   = 3'b001,
      ALU_ADD  = 3'b010,
      ALU_XOR  = 3'b011,
      ALU_NOR  = 3'b100,
      ALU_RSV  = 3'b101,
      ALU_SUB  = 3'b110,
      ALU_SLT  = 3'b111
   } alu_op_e;

   function automatic logic op_uses_adder(input alu_op_e op);
      return (op == ALU_ADD) || (op == ALU_SUB) || (op == ALU_SLT);
   endfunction
endpackage

// File: rtl/intalu_adder.sv
module intalu_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic             invert_b,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   chain;

   assign b_eff    = invert_b ? ~in_b : in_b;
   assign chain[0] = invert_b;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic gen_t, prop_t;
      assign prop_t     = in_a[i] ^ b_eff[i];
      assign gen_t      = in_a[i] & b_eff[i];
      assign sum_o[i]   = prop_t ^ chain[i];
      assign chain[i+1] = gen_t | (prop_t & chain[i]);
   end

   assign carry_o = chain[WIDTH];
   assign ovf_o   = (in_a[MSB] == b_eff[MSB]) && (sum_o[MSB] != in_a[MSB]);
endmodule

// File: rtl/intalu_logic.sv
module intalu_logic #(
   parameter int WIDTH   = 32,
   parameter bit EXT_OPS = 1'b1
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic [WIDTH-1:0] xor_o,
   output logic [WIDTH-1:0] nor_o
);
   assign and_o = in_a & in_b;
   assign or_o  = in_a | in_b;

   if (EXT_OPS) begin : g_ext
      assign xor_o = in_a ^ in_b;
      // not-or built as OR then XOR with all ones
      assign nor_o = or_o ^ {WIDTH{1'b1}};
   end else begin : g_noext
      assign xor_o = '0;
      assign nor_o = '0;
   end
endmodule

// File: rtl/intalu_flags.sv
module intalu_flags #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] result,
   input  logic             diff_sign,
   input  logic             diff_ovf,
   output logic             zero_o,
   output logic [WIDTH-1:0] less_o
);
   assign zero_o = ~|result;
   // sign corrected by overflow gives the true signed ordering
   assign less_o = {{(WIDTH-1){1'b0}}, diff_sign ^ diff_ovf};
endmodule

// File: rtl/intalu_core.sv
module intalu_core
   import intalu_pkg::*;
#(
   parameter int WIDTH   = 32,
   parameter bit EXT_OPS = 1'b1
) (
   input  logic [WIDTH-1:0] opd_a,
   input  logic [WIDTH-1:0] opd_b,
   input  logic [2:0]       op_sel,
   output logic [WIDTH-1:0] res_o,
   output logic             zero_o,
   output logic             cout_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("intalu_core: WIDTH must be at least 2");
   end

   alu_op_e          op;
   logic [WIDTH-1:0] sum_w, and_w, or_w, xor_w, nor_w, less_w;
   logic             add_c, add_v, do_sub;

   assign op     = alu_op_e'(op_sel);
   assign do_sub = (op == ALU_SUB) || (op == ALU_SLT);

   intalu_adder #(.WIDTH(WIDTH)) u_add (
      .in_a(opd_a), .in_b(opd_b), .invert_b(do_sub),
      .sum_o(sum_w), .carry_o(add_c), .ovf_o(add_v)
   );

   intalu_logic #(.WIDTH(WIDTH), .EXT_OPS(EXT_OPS)) u_log (
      .in_a(opd_a), .in_b(opd_b),
      .and_o(and_w), .or_o(or_w), .xor_o(xor_w), .nor_o(nor_w)
   );

   intalu_flags #(.WIDTH(WIDTH)) u_flg (
      .result(res_o), .diff_sign(sum_w[MSB]), .diff_ovf(add_v),
      .zero_o(zero_o), .less_o(less_w)
   );

   always_comb begin
      unique case (op)
         ALU_AND: res_o = and_w;
         ALU_OR:  res_o = or_w;
         ALU_ADD: res_o = sum_w;
         ALU_SUB: res_o = sum_w;
         ALU_SLT: res_o = less_w;
         ALU_XOR: res_o = xor_w;
         ALU_NOR: res_o = nor_w;
         default: res_o = '0;
      endcase
   end

   assign cout_o = (op == ALU_ADD || op == ALU_SUB) ? add_c : 1'b0;
   assign ovf_o  = (op == ALU_ADD || op == ALU_SUB) ? add_v : 1'b0;
endmodule

// File: rtl/intalu_core_chk.sv
module intalu_core_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opd_a,
   input logic [WIDTH-1:0] opd_b,
   input logic [2:0]       op_sel,
   input logic [WIDTH-1:0] res_o,
   input logic             zero_o,
   input logic             cout_o,
   input logic             ovf_o
);
   always_comb begin
      // R1
      and_subset_chk: assert (op_sel != 3'b000 || (res_o & ~opd_a) == '0);
      // R2
      or_cover_chk: assert (op_sel != 3'b001 || (res_o | opd_a) == res_o);
      // R5
      slt_upper_chk: assert (op_sel != 3'b111 || (res_o[WIDTH-1:1] == '0 && !cout_o && !ovf_o));
      // R8
      logic_flags_chk: assert (!(op_sel inside {3'b000, 3'b001, 3'b011, 3'b100}) || (!cout_o && !ovf_o));
      // R7
      no_overflow_chk: assert (!(op_sel == 3'b010 && opd_a[WIDTH-1] != opd_b[WIDTH-1]) || !ovf_o);
      // R4
      sub_equal_chk: assert (!(op_sel == 3'b110 && opd_a == opd_b) || (zero_o && cout_o));
      // R11
      rsv_quiet_chk: assert (op_sel != 3'b101 || (res_o == '0 && zero_o && !cout_o && !ovf_o));
   end
endmodule

bind intalu_core intalu_core_chk #(.WIDTH(WIDTH)) u_chk (
   .opd_a(opd_a), .opd_b(opd_b), .op_sel(op_sel), .res_o(res_o),
   .zero_o(zero_o), .cout_o(cout_o), .ovf_o(ovf_o)
);

// File: tb/intalu_core_tb.sv
module intalu_core_tb;
   localparam int W = 8;

   typedef struct {
      logic [2:0]   op;
      logic [W-1:0] a, b, res;
      logic         z, c, v;
   } exp_t;

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic [W-1:0] a = '0, b = '0, res;
   logic [2:0]   op = 3'b000;
   logic         zero, cout, ovf;
   int checks = 0, errors = 0, cycles = 0;
   exp_t q[$];

   intalu_core #(.WIDTH(W), .EXT_OPS(1'b1)) u_dut (
      .opd_a(a), .opd_b(b), .op_sel(op),
      .res_o(res), .zero_o(zero), .cout_o(cout), .ovf_o(ovf)
   );

   function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                  input logic [2:0] o);
      exp_t e;
      logic [W:0] s;
      e.op = o; e.a = x; e.b = y; e.c = 0; e.v = 0; e.res = '0;
      case (o)
         3'b000: e.res = x & y;                               // R1
         3'b001: e.res = x | y;                               // R2
         3'b010: begin                                        // R3 R7
            s = {1'b0, x} + {1'b0, y};
            e.res = s[W-1:0]; e.c = s[W];
            e.v = ($signed(x) + $signed(y)) > 127 || ($signed(x) + $signed(y)) < -128;
         end
         3'b110: begin                                        // R4 R7
            s = {1'b0, x} + {1'b0, ~y} + 1;
            e.res = s[W-1:0]; e.c = s[W];
            e.v = ($signed(x) - $signed(y)) > 127 || ($signed(x) - $signed(y)) < -128;
         end
         3'b111: e.res = ($signed(x) < $signed(y)) ? 1 : 0;    // R5
         3'b011: e.res = x ^ y;                               // R9
         3'b100: e.res = ~(x | y);                            // R10
         default: e.res = '0;                                 // R11
      endcase
      e.z = (e.res == '0);                                    // R6
      return e;
   endfunction

   function automatic string req_of(input logic [2:0] o);
      case (o)
         3'b000: return "R1"; 3'b001: return "R2"; 3'b010: return "R3";
         3'b110: return "R4"; 3'b111: return "R5"; 3'b011: return "R9";
         3'b100: return "R10"; default: return "R11";
      endcase
   endfunction

   task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] o);
      @(posedge clk);
      #1;
      a = x; b = y; op = o;
      q.push_back(model(x, y, o));
   endtask

   // monitor: compare mid-cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (res !== e.res) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h result got %h exp %h", req_of(e.op), e.op, e.a, e.b, res, e.res);
         end
         if (zero !== e.z) begin
            errors++;
            $display("FAIL R6 op=%b a=%h b=%h zero got %b exp %b", e.op, e.a, e.b, zero, e.z);
         end
         if (cout !== e.c) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h carry got %b exp %b",
                     (e.op == 3'b010 || e.op == 3'b110) ? req_of(e.op) : "R8", e.op, e.a, e.b, cout, e.c);
         end
         if (ovf !== e.v) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h overflow got %b exp %b",
                     (e.op == 3'b010 || e.op == 3'b110) ? "R7" : "R8", e.op, e.a, e.b, ovf, e.v);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] corner [6];
      logic [15:0]  lfsr;
      corner[0] = 8'h00; corner[1] = 8'h01; corner[2] = 8'hFF;
      corner[3] = 8'h7F; corner[4] = 8'h80; corner[5] = 8'h55;
      repeat (3) @(posedge clk);
      rst_n = 1;
      // reset-state check: idle inputs give a zero AND result
      drive('0, '0, 3'b000);
      // directed corners, incl. overflowing compares for R5 and R7
      for (int o = 0; o < 8; o++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               drive(corner[i], corner[j], 3'(o));
      // R5 overflow-corrected compare: -128 vs 1 and 127 vs -1
      drive(8'h80, 8'h01, 3'b111);
      drive(8'h7F, 8'hFF, 3'b111);
      // R4 equal operands give zero and carry
      drive(8'h3C, 8'h3C, 3'b110);
      lfsr = 16'hACE1;
      for (int n = 0; n < 2000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[7:0], lfsr[15:8], 3'(n % 8));
      end
      @(posedge clk);
      @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule